// File: doc/BRIEF.md
# Vector Length Setting Unit

This unit executes a set-vector-length operation. Each request carries a requested element count (the value of the source register), a flag that says the source is the hard-wired zero register, and an immediate that gives the maximum vector length for the loop. The unit computes a new vector length and writes it into its vector length register. One cycle later it returns the same value as the destination-register writeback.

A per-request mode bit selects one of two policies. The clamp policy takes the smaller of the requested count and the maximum. The halving policy first saturates very long requests at the maximum. A remainder that is longer than the maximum but no more than twice the maximum is split into two strips of about equal size, so the loop never ends on a very short iteration. An immediate wider than the machine word is illegal. It raises a trap pulse and leaves all state as it was.

The request side is always ready, so a request is accepted in the cycle its valid is high. Results are registered.

Top module: `vl_set_unit`

## Requirements
- R1: After reset the vector length output is 0, and neither the writeback-valid pulse nor the trap pulse is high.
- R2: With the clamp policy (`req_halve`=0), the new vector length is min(request, immediate). It appears on `vl_o`, and on `rd_data` with `rd_valid` high, exactly one cycle after the accepting edge. `rd_data` equals `vl_o` whenever `rd_valid` is high.
- R3: When `req_src_zero`=1, the new vector length equals the immediate in both policies, whatever the value of `req_avl`.
- R4: An immediate greater than XLEN gives a one-cycle `trap_o` pulse on the next cycle, with no `rd_valid` and `vl_o` unchanged. An immediate equal to XLEN is legal.
- R5: With the halving policy, a request strictly greater than twice the immediate gives a vector length equal to the immediate.
- R6: With the halving policy, a request greater than the immediate and at most twice the immediate gives half the request. The half is rounded up when parameter ROUND_UP=1 and rounded down when ROUND_UP=0.
- R7: With the halving policy, a request at or below the immediate is passed through unchanged.
- R8: A request of 0 from a non-zero source register gives a vector length of 0 with no trap, in both policies.
- R9: In a cycle with no accepted request, `vl_o` keeps its value and neither pulse output rises.
- R10: Requests up to 2^XLEN-1 cause no overflow. All-ones with the halving policy saturates at the immediate, and with the clamp policy gives the immediate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_ready | output | 1 | Request accepted; always high |
| req_avl | input | XLEN | Requested element count from the source register |
| req_src_zero | input | 1 | Source register is the zero register |
| req_maxvl | input | IMM_W | Maximum vector length immediate |
| req_halve | input | 1 | 1 = halving policy, 0 = clamp policy |
| vl_o | output | XLEN | Vector length register |
| rd_valid | output | 1 | One-cycle writeback pulse |
| rd_data | output | XLEN | Writeback value for the destination register |
| trap_o | output | 1 | One-cycle illegal-immediate pulse |

## Verification
Every result is due exactly one clock edge after the edge that accepts its request. The writeback pulse, the trap pulse and the updated vector length all show in the cycle that follows. The driver changes inputs on the falling edge and puts the expected outcome in a queue. The monitor samples a quarter period after each rising edge. Whenever the queue holds an item, that sample must show it; any other sample must show no pulse and an unchanged length. A second instance with round-down halving runs on the same stimulus and is checked against its own expected length.

// File: rtl/vl_set_unit.sv
module vl_set_unit #(
  parameter int XLEN     = 64,
  parameter int IMM_W    = 11,
  parameter bit ROUND_UP = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [XLEN-1:0]  req_avl,
  input  logic             req_src_zero,
  input  logic [IMM_W-1:0] req_maxvl,
  input  logic             req_halve,
  output logic [XLEN-1:0]  vl_o,
  output logic             rd_valid,
  output logic [XLEN-1:0]  rd_data,
  output logic             trap_o
);
  localparam int CW = XLEN + 1;
  localparam logic [CW-1:0] LIMIT = CW'(XLEN);

  logic [CW-1:0] avl_w, max_w, twice_w, half_w;
  logic [CW-1:0] next_w;
  logic          illegal;
  logic [XLEN-1:0] vl_q;
  logic            rdv_q, trap_q;

  assign req_ready = 1'b1;
  assign avl_w   = {1'b0, req_avl};
  assign max_w   = {{(CW-IMM_W){1'b0}}, req_maxvl};
  assign twice_w = max_w << 1;
  assign illegal = max_w > LIMIT;

  generate
    if (ROUND_UP) begin : g_ceil
      assign half_w = (avl_w + CW'(1)) >> 1;
    end else begin : g_floor
      assign half_w = avl_w >> 1;
    end
  endgenerate

  always_comb begin
    if (req_src_zero)        next_w = max_w;
    else if (!req_halve)     next_w = (avl_w < max_w) ? avl_w : max_w;
    else if (avl_w > twice_w) next_w = max_w;
    else if (avl_w > max_w)  next_w = half_w;
    else                     next_w = avl_w;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vl_q   <= '0;
      rdv_q  <= 1'b0;
      trap_q <= 1'b0;
    end else begin
      rdv_q  <= req_valid && !illegal;
      trap_q <= req_valid && illegal;
      if (req_valid && !illegal) vl_q <= next_w[XLEN-1:0];
    end
  end

  assign vl_o     = vl_q;
  assign rd_valid = rdv_q;
  assign rd_data  = vl_q;
  assign trap_o   = trap_q;

  p_rd_match_vl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> rd_data == vl_o);

  p_trap_keeps_vl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> ($stable(vl_o) && !rd_valid));

  p_trap_from_imm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_maxvl > IMM_W'(XLEN)) |=> trap_o);

  p_vl_bounded_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> vl_o <= XLEN'(XLEN));

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rd_valid && !trap_o && $stable(vl_o)));
endmodule

// File: tb/vl_set_unit_tb.sv
module vl_set_unit_tb;
  localparam int XLEN = 64;
  localparam int IMM_W = 11;

  typedef struct {
    logic            trap;
    logic [XLEN-1:0] vl_up;
    logic [XLEN-1:0] vl_dn;
    string           tag;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_src_zero = 1'b0, req_halve = 1'b0;
  logic [XLEN-1:0] req_avl = '0;
  logic [IMM_W-1:0] req_maxvl = '0;
  logic req_ready, rd_valid, trap_o, rdy2, rdv2, trap2;
  logic [XLEN-1:0] vl_o, rd_data, vl2, rdd2;

  int checks = 0, failures = 0;
  exp_t sb[$];
  logic [XLEN-1:0] mod_up = '0, mod_dn = '0;
  bit running = 1'b1;

  always #10 clk = ~clk;

  vl_set_unit #(.XLEN(XLEN), .IMM_W(IMM_W), .ROUND_UP(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_avl(req_avl), .req_src_zero(req_src_zero), .req_maxvl(req_maxvl),
    .req_halve(req_halve), .vl_o(vl_o), .rd_valid(rd_valid), .rd_data(rd_data),
    .trap_o(trap_o));

  vl_set_unit #(.XLEN(XLEN), .IMM_W(IMM_W), .ROUND_UP(1'b0)) u_dut_floor (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy2),
    .req_avl(req_avl), .req_src_zero(req_src_zero), .req_maxvl(req_maxvl),
    .req_halve(req_halve), .vl_o(vl2), .rd_valid(rdv2), .rd_data(rdd2),
    .trap_o(trap2));

  function automatic logic [XLEN-1:0] model(input logic [XLEN-1:0] avl,
      input logic z, input logic [IMM_W-1:0] imm, input logic h, input logic up);
    logic [XLEN:0] a, m;
    a = {1'b0, avl};
    m = (XLEN+1)'(imm);
    if (z) return m[XLEN-1:0];
    if (!h) return (a < m) ? a[XLEN-1:0] : m[XLEN-1:0];
    if (a > 2 * m) return m[XLEN-1:0];
    if (a > m) return up ? XLEN'(a / 2 + a % 2) : XLEN'(a / 2);
    return a[XLEN-1:0];
  endfunction

  task automatic check(input bit ok, input string tag, input logic [XLEN-1:0] act,
                       input logic [XLEN-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(input logic [XLEN-1:0] avl, input logic z,
      input logic [IMM_W-1:0] imm, input logic h, input string tag);
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1; req_avl = avl; req_src_zero = z; req_maxvl = imm; req_halve = h;
    e.trap = (imm > IMM_W'(XLEN));
    if (!e.trap) begin
      mod_up = model(avl, z, imm, h, 1'b1);
      mod_dn = model(avl, z, imm, h, 1'b0);
    end
    e.vl_up = mod_up; e.vl_dn = mod_dn; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0; req_avl = '1; req_maxvl = '1; req_src_zero = 1'b0;
    end
  endtask

  always @(posedge clk) begin
    if (rst_n && running) begin
      #5;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(trap_o == e.trap && trap2 == e.trap, {e.tag, " trap"}, XLEN'(trap_o), XLEN'(e.trap));
        check(rd_valid == !e.trap && rdv2 == !e.trap, {e.tag, " rd_valid"}, XLEN'(rd_valid), XLEN'(!e.trap));
        check(vl_o == e.vl_up, {e.tag, " vl"}, vl_o, e.vl_up);
        check(vl2 == e.vl_dn, {e.tag, " vl floor"}, vl2, e.vl_dn);
        if (!e.trap) check(rd_data == e.vl_up, {e.tag, " rd_data R2"}, rd_data, e.vl_up);
      end else begin
        check(!rd_valid && !trap_o && !rdv2 && !trap2, "R9 no pulse when idle",
              XLEN'({rd_valid, trap_o}), '0);
        check(vl_o == mod_up && vl2 == mod_dn, "R9 vl held when idle", vl_o, mod_up);
      end
    end
  end

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(vl_o == 0 && vl2 == 0, "R1 reset vl", vl_o, '0);
    check(!rd_valid && !trap_o, "R1 reset pulses", XLEN'({rd_valid, trap_o}), '0);
    check(req_ready == 1'b1, "R2 ready", XLEN'(req_ready), 1);
    rst_n = 1'b1;
    idle(2);
    send(64'd1000, 0, 11'd8, 0, "R2 clamp long");
    send(64'd5, 0, 11'd8, 0, "R2 clamp short");
    idle(1);
    send(64'd8, 0, 11'd8, 0, "R2 clamp equal");
    send(64'd5, 0, 11'd0, 0, "R2 clamp imm zero");
    send(64'd999, 1, 11'd20, 0, "R3 zero src clamp");
    send(64'd3, 1, 11'd40, 1, "R3 zero src halve");
    send(64'd7, 0, 11'd65, 0, "R4 imm over xlen");
    idle(2);
    send(64'd9, 1, 11'd2047, 1, "R4 imm max");
    send(64'd100, 0, 11'd64, 0, "R4 imm equal xlen");
    send(64'd17, 0, 11'd8, 1, "R5 halve above twice");
    send(64'd16, 0, 11'd8, 1, "R6 halve at twice");
    send(64'd15, 0, 11'd8, 1, "R6 halve odd");
    send(64'd9, 0, 11'd8, 1, "R6 halve just above");
    send(64'd8, 0, 11'd8, 1, "R7 halve at max");
    send(64'd3, 0, 11'd8, 1, "R7 halve below");
    send(64'd0, 0, 11'd8, 1, "R8 zero halve");
    send(64'd44, 0, 11'd16, 0, "R2 refill");
    send(64'd0, 0, 11'd8, 0, "R8 zero clamp");
    send('1, 0, 11'd64, 1, "R10 all ones halve");
    send(64'd0, 0, 11'd3, 0, "R8 zero reload");
    send('1, 0, 11'd64, 0, "R10 all ones clamp");
    send({1'b1, 63'd0}, 0, 11'd33, 1, "R10 top bit halve");
    idle(4);
    running = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule